// File: doc/BRIEF.md
# Nine-Bit Word FIFO with Occupancy Flags and Rewind

The block buffers 9-bit words between a producer that presents one word per clock with a write strobe and a consumer that pulls words with an active-low read strobe. Everything runs on one clock, which samples both strobes. A read happens once for each high-to-low transition of the read strobe seen by that clock. Holding the strobe low does not read again. The word that was read stays in an output register until the next read.

The output is meant for a shared bus. The block supplies the output word and a drive-enable signal, and the pad ring turns these into a three-state driver. The drive enable comes on only while the read strobe, as last sampled, is low and the active-low output enable is low at the same time.

Five flags report occupancy: empty, almost-empty, half-full, almost-full and full. Their thresholds are derived from the depth parameter. A rewind input moves the read position back to the first word written since reset, so that a stored message can be replayed. This only gives a meaningful result when no more words than the depth have been written since reset.

Top module: `fifo9_rt`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both positions and the output register. After reset, `empty_o` and `aempty_o` are 1, `full_o`, `afull_o` and `half_o` are 0, `q_en` is 0 and `q_data` is 0.
- R2: Words are returned on `q_data` in the order they were written. The new word appears after the clock edge at which the read is taken.
- R3: `full_o` is 1 exactly when DEPTH words are stored. A write while `full_o` is 1 is dropped and changes no stored word.
- R4: A read is taken at a clock edge where `rd_n` is 0 and `rd_n` was 1 at the previous edge (1 is assumed before the first edge after reset). A read attempted while `empty_o` is 1 is ignored and leaves `q_data` unchanged.
- R5: `q_en` is 0 whenever `rd_n` was 1 at the last clock edge, whatever `oe_n` is. Otherwise `q_en` equals the inverse of `oe_n`.
- R6: `afull_o` is 1 when occupancy is at least DEPTH - DEPTH/8 (1792 for 2048).
- R7: `half_o` is 1 when occupancy is at least DEPTH/2 (1024 for 2048).
- R8: `aempty_o` is 1 when occupancy is at most DEPTH/8 (256 for 2048).
- R9: A write and a read taken at the same edge leave occupancy unchanged. If the block is empty at that edge, only the write takes effect.
- R10: `rt` high at a clock edge sets the next read back to the first word written since reset, and occupancy becomes the number of words written since reset. A read falling on that same edge is not taken; a write on that edge is.
- R11: `empty_o` is 1 exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per clock while high |
| wr_data | input | 9 | Word to write |
| rd_n | input | 1 | Active-low read strobe, read on its falling transition |
| oe_n | input | 1 | Active-low output enable |
| rt | input | 1 | Rewind the read position to the first word since reset |
| q_data | output | 9 | Last word read |
| q_en | output | 1 | Bus drive enable for `q_data` |
| full_o | output | 1 | DEPTH words stored |
| afull_o | output | 1 | Occupancy at or above seven eighths |
| half_o | output | 1 | Occupancy at or above one half |
| aempty_o | output | 1 | Occupancy at or below one eighth |
| empty_o | output | 1 | No word stored |

## Verification
The hardest case to reach from the ports is the region at the top of the buffer. There, writes must be refused at exactly DEPTH words, and the almost-full flag must change at DEPTH - DEPTH/8. Reaching it takes thousands of writes with no read in between.

The stimulus fills the buffer with a long run of writes, keeping `rd_n` high the whole time, and pushes two extra words once the buffer is full. It then drains part of the buffer with read pulses, crossing each threshold again from above. A behavioural queue model is compared against every flag and the output on every clock. Rewind is exercised with a read falling on the same edge as `rt`, so the rule that the rewind wins that edge is tested.

// File: rtl/fifo9_pkg.sv
// Package: shared types for the nine-bit FIFO.
// Assumes nothing beyond IEEE 1800-2017.
package fifo9_pkg;

    // Occupancy flags, all active high
    typedef struct packed {
        logic full;
        logic afull;
        logic half;
        logic aempty;
        logic empty;
    } fifo9_flags_t;

endpackage

// File: rtl/fifo9_strobe.sv
// Module: samples the active-low read strobe, produces a one-cycle
// read request on its falling transition and the bus drive enable.
// Assumes rd_n and oe_n are synchronous to clk.
module fifo9_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic oe_n,
    output logic rd_fall,
    output logic drive_en
);
    logic rd_n_q;

    // Hold the strobe level seen at the previous edge (idle high after reset)
    always_ff @(posedge clk) begin
        if (!rst_n) rd_n_q <= 1'b1;
        else        rd_n_q <= rd_n;
    end

    // Falling transition between the previous and the present sample
    always_comb rd_fall = rd_n_q && !rd_n;

    // Drive only while the sampled strobe is low and the enable is low
    always_comb drive_en = !rd_n_q && !oe_n;
endmodule

// File: rtl/fifo9_ptrs.sv
// Module: write and read positions with a wrap bit, occupancy and the
// accept decisions for push and pop. Rewind takes precedence over pop.
// Assumes DEPTH is a power of two.
module fifo9_ptrs #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_req,
    input  logic        pop_req,
    input  logic        rewind,
    output logic        push_ok,
    output logic        pop_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occ
);
    localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;

    // Occupancy is the distance between the positions
    always_comb occ = wr_ptr - rd_ptr;

    // Accept decisions from the present occupancy
    always_comb begin
        push_ok = push_req && (occ != CAP);
        pop_ok  = pop_req && (occ != '0) && !rewind;
    end

    always_comb begin
        wr_addr = wr_ptr[AW-1:0];
        rd_addr = rd_ptr[AW-1:0];
    end

    // Advance the write position on an accepted push
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr <= '0;
        else if (push_ok) wr_ptr <= wr_ptr + 1'b1;
    end

    // Rewind to the origin, otherwise advance on an accepted pop
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (rewind) rd_ptr <= '0;
        else if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
    end
endmodule

// File: rtl/fifo9_flags.sv
// Module: derives the five occupancy flags from the occupancy count.
// Assumes DEPTH is a power of two of at least 16.
module fifo9_flags
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW:0]  occ,
    output fifo9_flags_t flags
);
    localparam logic [AW:0] CAP    = (AW+1)'(DEPTH);
    localparam logic [AW:0] EIGHTH = (AW+1)'(DEPTH / 8);
    localparam logic [AW:0] HALF   = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] HIGHW  = (AW+1)'(DEPTH - DEPTH / 8);

    // Compare occupancy against each threshold
    always_comb begin
        flags.full   = (occ == CAP);
        flags.afull  = (occ >= HIGHW);
        flags.half   = (occ >= HALF);
        flags.aempty = (occ <= EIGHTH);
        flags.empty  = (occ == '0);
    end
endmodule

// File: rtl/fifo9_store.sv
// Module: word storage with one write port and an output register that
// loads the word at the read address when a pop is accepted.
// Assumes the storage content is undefined until written.
module fifo9_store #(
    parameter int W     = 9,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [W-1:0]  q
);
    logic [W-1:0] mem [DEPTH];

    // Store the accepted word
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    // Load the output register on an accepted pop
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[ra];
    end
endmodule

// File: rtl/fifo9_rt.sv
// Module: top of the nine-bit FIFO with five flags, a strobe-driven
// output and a rewind input.
// Assumes one clock; all inputs are synchronous to it.
module fifo9_rt
    import fifo9_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_n,
    input  logic         oe_n,
    input  logic         rt,
    output logic [W-1:0] q_data,
    output logic         q_en,
    output logic         full_o,
    output logic         afull_o,
    output logic         half_o,
    output logic         aempty_o,
    output logic         empty_o
);
    localparam int AW = $clog2(DEPTH);

    logic          rd_fall;
    logic          push_ok;
    logic          pop_ok;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [AW:0]   occ;
    fifo9_flags_t  flags;

    fifo9_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .oe_n     (oe_n),
        .rd_fall  (rd_fall),
        .drive_en (q_en)
    );

    fifo9_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .pop_req  (rd_fall),
        .rewind   (rt),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .occ      (occ)
    );

    fifo9_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_ok),
        .wa    (wr_addr),
        .wd    (wr_data),
        .re    (pop_ok),
        .ra    (rd_addr),
        .q     (q_data)
    );

    fifo9_flags #(.DEPTH(DEPTH)) u_flags (
        .occ   (occ),
        .flags (flags)
    );

    // Bring the flags out to the ports
    always_comb begin
        full_o   = flags.full;
        afull_o  = flags.afull;
        half_o   = flags.half;
        aempty_o = flags.aempty;
        empty_o  = flags.empty;
    end
endmodule

// Checker: temporal properties of the FIFO, bound to the top.
module fifo9_rt_chk #(
    parameter int W     = 9,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         rd_n,
    input logic         rt,
    input logic [W-1:0] q_data,
    input logic         q_en,
    input logic         full_o,
    input logic         afull_o,
    input logic         half_o,
    input logic         aempty_o,
    input logic         empty_o,
    input logic [AW:0]  occ
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (AW+1)'(DEPTH));

    // R11
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R5
    strobe_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> !q_en);

    // R4
    empty_holds_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !rt) |=> $stable(q_data));

    // R11
    empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !wr_en && !rt) |=> empty_o);

    // R3
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && rd_n && !rt) |=> full_o);

    // R6
    afull_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        afull_o |-> half_o);

    // R8
    half_excludes_aempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_o |-> !aempty_o);
endmodule

bind fifo9_rt fifo9_rt_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_n     (rd_n),
    .rt       (rt),
    .q_data   (q_data),
    .q_en     (q_en),
    .full_o   (full_o),
    .afull_o  (afull_o),
    .half_o   (half_o),
    .aempty_o (aempty_o),
    .empty_o  (empty_o),
    .occ      (occ)
);

// File: tb/fifo9_rt_test.sv
module fifo9_rt_test;
    localparam int W     = 9;
    localparam int DEPTH = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_n = 1'b1;
    logic         oe_n = 1'b1;
    logic         rt = 1'b0;
    logic [W-1:0] q_data;
    logic         q_en, full_o, afull_o, half_o, aempty_o, empty_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    int hist[$];
    int rdidx  = 0;
    int m_out  = 0;
    bit m_rdq  = 1'b1;

    always #4 clk = ~clk;

    fifo9_rt #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_n(rd_n), .oe_n(oe_n), .rt(rt), .q_data(q_data), .q_en(q_en),
        .full_o(full_o), .afull_o(afull_o), .half_o(half_o),
        .aempty_o(aempty_o), .empty_o(empty_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int occ_m();
        return hist.size() - rdidx;
    endfunction

    // Compare every output with the model (called away from the edge)
    task automatic compare();
        int o = occ_m();
        chk("R3",  "full",   full_o,   o == DEPTH);
        chk("R6",  "afull",  afull_o,  o >= DEPTH - DEPTH/8);
        chk("R7",  "half",   half_o,   o >= DEPTH/2);
        chk("R8",  "aempty", aempty_o, o <= DEPTH/8);
        chk("R11", "empty",  empty_o,  o == 0);
        chk("R5",  "q_en",   q_en,     (!m_rdq) && !oe_n);
        chk("R2",  "q_data", q_data,   m_out);
    endtask

    // Model of one clock edge with the inputs now applied
    task automatic model_edge();
        int  o     = occ_m();
        bit  fall  = m_rdq && !rd_n;
        if (!rst_n) begin
            hist.delete(); rdidx = 0; m_out = 0; m_rdq = 1'b1;
            return;
        end
        if (rt) rdidx = 0;
        else if (fall && o != 0) begin
            m_out = hist[rdidx]; rdidx++;
        end
        if (wr_en && o != DEPTH) hist.push_back(int'(wr_data));
        m_rdq = rd_n;
    endtask

    // One cycle: compare, apply new inputs, advance the model
    task automatic step(input bit w, input int d, input bit rn, input bit on, input bit r);
        @(negedge clk);
        compare();
        wr_en = w; wr_data = W'(d); rd_n = rn; oe_n = on; rt = r;
        model_edge();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; rd_n = 1; oe_n = 1; rt = 0;
        model_edge();
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        model_edge();
    endtask

    // One read pulse: strobe low then high, output enabled
    task automatic read_pulse();
        step(0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
    endtask

    initial begin
        fork
            begin
                repeat (190000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        join_none

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1", "empty", empty_o, 1);  chk("R1", "aempty", aempty_o, 1);
        chk("R1", "full",  full_o,  0);  chk("R1", "afull",  afull_o,  0);
        chk("R1", "half",  half_o,  0);  chk("R1", "q_en",   q_en,     0);
        chk("R1", "q_data", q_data, 0);

        // R4: read while empty is ignored
        read_pulse();
        // R2: order of a short burst
        for (int i = 0; i < 6; i++) step(1, 9'h100 + i * 37, 1, 0, 0);
        for (int i = 0; i < 6; i++) read_pulse();
        // R4: strobe held low reads once; R5: oe_n toggled while low
        for (int i = 0; i < 3; i++) step(1, 50 + i, 1, 1, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        // R9: write and read at the same edge
        step(1, 77, 0, 0, 0);
        step(1, 78, 1, 0, 0);
        step(1, 79, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) read_pulse();
        // R9: write and read at the same edge while empty
        step(1, 300, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        read_pulse();

        // R3, R6, R7, R8: fill past capacity, then drain across thresholds
        do_reset();
        for (int i = 0; i < DEPTH + 2; i++) step(1, (i * 13 + 5) % 512, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        for (int i = 0; i < DEPTH - DEPTH/8 + 4; i++) read_pulse();
        for (int i = 0; i < DEPTH/2; i++) read_pulse();

        // R10: rewind replays data, read on the rewind edge is not taken
        do_reset();
        for (int i = 0; i < 10; i++) step(1, 400 + i, 1, 0, 0);
        for (int i = 0; i < 4; i++) read_pulse();
        step(0, 0, 0, 0, 1);
        step(1, 420, 1, 0, 0);
        for (int i = 0; i < 12; i++) read_pulse();
        step(0, 0, 1, 0, 0);

        @(negedge clk);
        compare();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule